// File: doc/BRIEF.md
# Dual-Output Compare-Action Waveform Timer

One timer channel that generates two waveforms, A and B, from a single up-counter. The counter runs from zero up to the period register and then wraps to zero. Because of this, both outputs always have the same period. Each output has no fixed comparator. Instead it has three programmable actions: set, clear, toggle or none. One action fires on its own duty compare (register RA for A, RB for B), one on the shared period compare, and one on a software trigger. A normal PWM clears on the duty compare and sets on the period compare. An inverted PWM swaps those two actions.

A simple write port loads the mode word, the three compare registers and a command word. The command word enables the clock, disables it, or fires a software trigger. The trigger zeroes the counter and applies each output's trigger action, even while the clock is stopped. Software uses this to start the channel cleanly, or to park an output at a fixed level when the duty is zero or full. A prescaler divides the system clock, or the counter can follow a slow-tick input.

Top module: `wave_timer`

## Requirements
- R1: After reset both outputs are 0, the counter is 0, the channel is stopped and every register reads as zero.
- R2: While running, the counter advances by one on each selected tick. A tick that finds the counter equal to RC returns it to 0, so a period lasts RC+1 ticks.
- R3: Write addresses are 0 mode, 1 RA, 2 RB, 3 RC, 4 command. Mode bits [2:0] select the clock. Bits [4:3], [6:5] and [8:7] are the A actions for the RA compare, the RC compare and the trigger. Bits [10:9], [12:11] and [14:13] are the same three B actions, with RB as the duty compare. Each action field uses 00 none, 01 set, 10 clear, 11 toggle.
- R4: A duty compare fires on a tick that finds the counter equal to RA (output A) or RB (output B). With the duty compare set to clear and the period compare set to set, the output is high for duty+1 ticks of each period. With the two actions swapped, it is high for RC-duty ticks.
- R5: Command bit 2 (the software trigger) zeroes the counter at the next edge and applies each output's trigger action. This happens whether or not the clock is enabled.
- R6: When events coincide, only the highest-priority event acts, even if its action is none. The order is software trigger first, then the RC compare, then the duty compare.
- R7: Command bit 0 enables the clock and bit 1 disables it. If both are set, the clock ends up disabled. While the clock is disabled, the counter and both outputs hold their values.
- R8: Clock select 0 ticks on every cycle, 1 on every 2nd, 2 on every 8th and 3 on every 32nd. Select 4 ticks on each cycle where slow_tick is high. Selects 5 to 7 give no ticks.
- R9: Output B follows RB and its own action fields, and shares the counter and RC with output A.
- R10: With RC = 0xFFFF the counter reaches 0xFFFF and then wraps to 0, so a period is 65536 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow-clock enable pulse, used as the tick when select is 4 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 mode, 1 RA, 2 RB, 3 RC, 4 command) |
| wr_data | input | 16 | Write data |
| out_a | output | 1 | Waveform A |
| out_b | output | 1 | Waveform B |
| count | output | 16 | Current counter value |
| running | output | 1 | Clock-enabled state |

## Verification
A wrong counter value shows on `count` within one tick. It also moves the compare edges, so the number of high cycles per period measured on `out_a` or `out_b` comes out wrong in the first period after a start. A wrong enable state shows as a counter that moves while it should be frozen, or stays frozen while it should move, at the next tick. A wrong event priority shows on the output level at the edge where the events collide. A wrong prescaler phase or divisor shows as a wrong tick count over a fixed window.

// File: rtl/wave_timer.sv
module wave_timer #(
  parameter int CNT_W      = 16,
  parameter int DIV1_LOG2  = 1,
  parameter int DIV2_LOG2  = 3,
  parameter int DIV3_LOG2  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             out_a,
  output logic             out_b,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  localparam int MODE_W = 15;
  localparam int PSC_W  = DIV3_LOG2;

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  ra_q, rb_q, rc_q, cnt_q;
  logic [PSC_W-1:0]  psc_q;
  logic              run_q, oa_q, ob_q, tick;

  wire cmd_wr   = wr_en && wr_addr == 3'd4;
  wire sw_fire  = cmd_wr && wr_data[2];
  wire adv      = run_q && tick && !sw_fire;
  wire rc_hit   = adv && cnt_q == rc_q;
  wire ra_hit   = adv && cnt_q == ra_q;
  wire rb_hit   = adv && cnt_q == rb_q;

  always_comb begin
    case (mode_q[2:0])
      3'd0:    tick = 1'b1;
      3'd1:    tick = &psc_q[DIV1_LOG2-1:0];
      3'd2:    tick = &psc_q[DIV2_LOG2-1:0];
      3'd3:    tick = &psc_q[DIV3_LOG2-1:0];
      3'd4:    tick = slow_tick;
      default: tick = 1'b0;
    endcase
  end

  function automatic logic act(input logic cur, input logic [1:0] a);
    case (a)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  wire oa_nx = sw_fire ? act(oa_q, mode_q[8:7])   :
               rc_hit  ? act(oa_q, mode_q[6:5])   :
               ra_hit  ? act(oa_q, mode_q[4:3])   : oa_q;
  wire ob_nx = sw_fire ? act(ob_q, mode_q[14:13]) :
               rc_hit  ? act(ob_q, mode_q[12:11]) :
               rb_hit  ? act(ob_q, mode_q[10:9])  : ob_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      rc_q   <= '0;
      cnt_q  <= '0;
      psc_q  <= '0;
      run_q  <= 1'b0;
      oa_q   <= 1'b0;
      ob_q   <= 1'b0;
    end else begin
      psc_q <= psc_q + 1'b1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: mode_q <= wr_data[MODE_W-1:0];
          3'd1: ra_q   <= wr_data;
          3'd2: rb_q   <= wr_data;
          3'd3: rc_q   <= wr_data;
          default: ;
        endcase
      end
      if (cmd_wr && wr_data[1])      run_q <= 1'b0;
      else if (cmd_wr && wr_data[0]) run_q <= 1'b1;
      if (sw_fire)     cnt_q <= '0;
      else if (rc_hit) cnt_q <= '0;
      else if (adv)    cnt_q <= cnt_q + 1'b1;
      oa_q <= oa_nx;
      ob_q <= ob_nx;
    end
  end

  assign out_a   = oa_q;
  assign out_b   = ob_q;
  assign count   = cnt_q;
  assign running = run_q;

  assert_trigger_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> cnt_q == '0);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !sw_fire) |=> ($stable(cnt_q) && $stable(out_a) && $stable(out_b)));

  assert_disable_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[1]) |=> !running);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !sw_fire && count == rc_q) |=> count == '0);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !sw_fire && count != rc_q) |=> count == CNT_W'($past(count) + 1'b1));

  assert_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:0] > 3'd4 && !sw_fire) |=> $stable(count));
endmodule

// File: tb/tb_wave_timer.sv
module tb_wave_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        out_a, out_b, running;
  logic [15:0] count;
  int checks = 0;
  int errors = 0;

  wave_timer dut (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_a(out_a), .out_b(out_b),
    .count(count), .running(running));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [2:0] sel,
      input logic [1:0] ac, input logic [1:0] ar, input logic [1:0] as,
      input logic [1:0] bc, input logic [1:0] br, input logic [1:0] bs);
    return {1'b0, bs, br, bc, as, ar, ac, sel};
  endfunction

  task automatic stop_clear();
    wr(3'd4, 16'h0006);
  endtask

  task automatic t_reset();
    chk("R1 out_a", out_a, 0);
    chk("R1 out_b", out_b, 0);
    chk("R1 count", count, 0);
    chk("R1 running", running, 0);
    wr(3'd4, 16'h0001);
    idle(4);
    chk("R1 rc zero keeps count 0", count, 0);
    wr(3'd4, 16'h0002);
  endtask

  task automatic t_pwm_normal();
    int ha = 0, hb = 0;
    wr(3'd0, mk(3'd0, 2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b01));
    wr(3'd1, 16'd3); wr(3'd2, 16'd6); wr(3'd3, 16'd9);
    wr(3'd4, 16'h0005);
    chk("R5 start count", count, 0);
    chk("R5 start out_a set", out_a, 1);
    for (int i = 0; i < 10; i++) begin
      ha += out_a; hb += out_b;
      @(negedge clk);
    end
    chk("R4 normal A high ticks", ha, 4);
    chk("R9 normal B high ticks", hb, 7);
    chk("R2 period wraps", count, 0);
    stop_clear();
  endtask

  task automatic t_pwm_inverted();
    int ha = 0;
    wr(3'd0, mk(3'd0, 2'b01, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00));
    wr(3'd1, 16'd3); wr(3'd3, 16'd9);
    wr(3'd4, 16'h0005);
    for (int i = 0; i < 10; i++) begin
      ha += out_a;
      @(negedge clk);
    end
    chk("R4 inverted A high ticks", ha, 6);
    stop_clear();
  endtask

  task automatic t_toggle();
    wr(3'd0, mk(3'd0, 2'b11, 2'b00, 2'b10, 2'b00, 2'b00, 2'b01));
    wr(3'd1, 16'd2); wr(3'd3, 16'd4);
    wr(3'd4, 16'h0005);
    chk("R3 trigger clear A", out_a, 0);
    chk("R3 trigger set B", out_b, 1);
    idle(3);
    chk("R3 toggle first", out_a, 1);
    idle(5);
    chk("R3 toggle second", out_a, 0);
    chk("R3 none keeps B", out_b, 1);
    stop_clear();
  endtask

  task automatic t_prio_rc();
    wr(3'd0, mk(3'd0, 2'b01, 2'b10, 2'b01, 2'b00, 2'b00, 2'b00));
    wr(3'd1, 16'd5); wr(3'd3, 16'd5);
    wr(3'd4, 16'h0005);
    idle(6);
    chk("R6 rc beats compare", out_a, 0);
    idle(6);
    chk("R6 rc beats compare again", out_a, 0);
    stop_clear();
  endtask

  task automatic t_prio_sw();
    wr(3'd0, mk(3'd0, 2'b00, 2'b10, 2'b01, 2'b00, 2'b00, 2'b00));
    wr(3'd1, 16'd100); wr(3'd3, 16'd3);
    wr(3'd4, 16'h0005);
    idle(3);
    chk("R6 at rc", count, 3);
    wr(3'd4, 16'h0004);
    chk("R6 trigger beats rc", out_a, 1);
    chk("R5 trigger zeroes", count, 0);
    stop_clear();
  endtask

  task automatic t_disable();
    logic [15:0] c0;
    logic a0;
    wr(3'd0, mk(3'd0, 2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b01));
    wr(3'd1, 16'd2); wr(3'd3, 16'd50);
    wr(3'd4, 16'h0005);
    idle(7);
    wr(3'd4, 16'h0002);
    c0 = count; a0 = out_a;
    chk("R7 stopped", running, 0);
    idle(6);
    chk("R7 count held", count, c0);
    chk("R7 out held", out_a, a0);
    wr(3'd4, 16'h0003);
    chk("R7 disable wins", running, 0);
    idle(3);
    chk("R7 still held", count, c0);
    wr(3'd0, mk(3'd0, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b01));
    wr(3'd4, 16'h0004);
    chk("R5 trigger while stopped count", count, 0);
    chk("R5 trigger while stopped A", out_a, 0);
    chk("R5 trigger while stopped B", out_b, 1);
    chk("R5 trigger keeps stopped", running, 0);
    stop_clear();
  endtask

  task automatic t_prescale();
    wr(3'd3, 16'd1000); wr(3'd1, 16'd999); wr(3'd2, 16'd999);
    wr(3'd0, mk(3'd1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
    wr(3'd4, 16'h0005);
    idle(16);
    chk("R8 div2", count, 8);
    wr(3'd0, mk(3'd2, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
    wr(3'd4, 16'h0004);
    idle(64);
    chk("R8 div8", count, 8);
    wr(3'd0, mk(3'd3, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
    wr(3'd4, 16'h0004);
    idle(128);
    chk("R8 div32", count, 4);
    wr(3'd0, mk(3'd4, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
    wr(3'd4, 16'h0004);
    idle(10);
    chk("R8 slow idle", count, 0);
    for (int i = 0; i < 3; i++) begin
      slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0; idle(2);
    end
    chk("R8 slow ticks", count, 3);
    wr(3'd0, mk(3'd6, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
    wr(3'd4, 16'h0004);
    idle(20);
    chk("R8 no source", count, 0);
    stop_clear();
  endtask

  task automatic t_max();
    wr(3'd0, mk(3'd0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
    wr(3'd3, 16'hFFFF);
    wr(3'd4, 16'h0005);
    idle(65535);
    chk("R10 top value", count, 65535);
    idle(1);
    chk("R10 wrap", count, 0);
    stop_clear();
  endtask

  initial begin
    #(2_000_000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pwm_normal();
    t_pwm_inverted();
    t_toggle();
    t_prio_rc();
    t_prio_sw();
    t_disable();
    t_prescale();
    t_max();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule